// File: doc/BRIEF.md
# Counter-Mode Block Cipher DMA Sequencer

This block moves a region of byte memory through an external block-cipher core that runs in counter mode. Data is handled in 16-byte blocks. For each block the engine fetches the bytes from memory and packs them into a 128-bit word. It hands that word, the programmed counter value and the selected key to the cipher core. When the core answers, the engine stores the 16 result bytes back to the same locations. It then advances by 16 bytes and repeats until the processed count reaches the programmed length.

A host drives a simple command port: a read or write strobe, a 16-bit address and 8-bit data. Through this port it programs a register page and starts the engine. The page holds the memory base, the length, a 128-bit counter, two 128-bit keys and a key-select byte. The host starts the engine by writing the start code 0x01 to address 0xFF00 while the engine is idle, and it can poll that same address for a busy flag. The memory side is a byte-wide valid/ready master. The cipher core sits behind a request/acknowledge port.

Top module: `ctr_blk_dma`

## Requirements
- R1: After a synchronous reset the engine is idle: `mem_req`, `cph_req` and `host_rdata` are 0, and every configuration register reads back as 0.
- R2: A host write of 0x01 to 0xFF00 while idle starts an operation and clears the processed-byte count. A write of any other value to 0xFF00 does not start one.
- R3: Register writes that arrive while the engine is busy are ignored.
- R4: No memory access happens in the cycle the start write is presented. In the cycle after it, the first read request is issued at the base address.
- R5: In the read phase, byte i of the block (i = 0..15) is read from (base + count + i) mod 2^16 and placed in bits [8i+7:8i] of the 128-bit block.
- R6: In the encrypt phase the cipher port carries the packed block, the counter register and the key. The key is key0 when key-select is 0 and key1 for any other key-select value. The engine waits for `cph_ack` before it moves on.
- R7: In the write-back phase, result bits [8i+7:8i] are stored to the same address the read phase used for byte i. The processed count then grows by 16, modulo 2^16.
- R8: After a write-back the engine starts another block while the new count is below the length, and otherwise returns to idle. A length of 0 therefore still processes one block, and bytes past the last block are untouched.
- R9: A host read returns, one cycle later on `host_rdata`, the addressed register byte. It returns 0 for an unmapped address and 0 in any cycle without a read. Register map, all in page 0xFF: 0x00 bit 0 = busy (start on write); 0x01 = key select; 0x02/0x03 = base low/high; 0x04/0x05 = length low/high; 0x10+k, 0x20+k and 0x30+k = byte k (bits [8k+7:8k]) of the counter, key0 and key1.
- R10: The busy bit reads 1 exactly while the engine is not idle. While idle, neither memory nor cipher requests are raised.
- R11: Each memory access moves one byte and completes in a cycle where `mem_req` and `mem_ready` are both high. While not ready, the request, address, direction and write data hold steady. A memory request and a cipher request are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_addr | input | 16 | Host command address |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Registered host read data |
| mem_req | output | 1 | Memory access valid |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | 16 | Memory byte address |
| mem_wdata | output | 8 | Memory write data |
| mem_ready | input | 1 | Memory accepts the access this cycle |
| mem_rdata | input | 8 | Memory read data, valid with `mem_ready` |
| cph_req | output | 1 | Cipher request |
| cph_block | output | 128 | Packed input block |
| cph_ctr | output | 128 | Counter-mode counter value |
| cph_key | output | 128 | Selected key |
| cph_ack | input | 1 | Cipher result valid |
| cph_result | input | 128 | Cipher output block |

## Verification
Two functions can meet in one cycle: a host register write and a sequencer step that depends on that register. The bench provokes this by writing a new base address right after the start command, while the read phase is already fetching. It then judges the outcome twice. The read-back base must still hold the old value, and the transformed bytes must appear at the old base. The same collision at the start edge is checked cycle by cycle: the start write must see no memory request, and the very next cycle must show a read at the base address.

// File: rtl/ctr_blk_dma_pkg.sv
`timescale 1ns/1ps
package ctr_blk_dma_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_READ = 2'd1,
    ST_ENC  = 2'd2,
    ST_WRBK = 2'd3
  } seq_state_t;

  // offsets inside the register page
  localparam logic [7:0] OFS_CTRL    = 8'h00;
  localparam logic [7:0] OFS_KSEL    = 8'h01;
  localparam logic [7:0] OFS_BASE_LO = 8'h02;
  localparam logic [7:0] OFS_BASE_HI = 8'h03;
  localparam logic [7:0] OFS_LEN_LO  = 8'h04;
  localparam logic [7:0] OFS_LEN_HI  = 8'h05;
  localparam logic [3:0] PG_CTR      = 4'h1;
  localparam logic [3:0] PG_KEY0     = 4'h2;
  localparam logic [3:0] PG_KEY1     = 4'h3;
  localparam logic [7:0] START_CODE  = 8'h01;
endpackage

// File: rtl/cbd_regs.sv
`timescale 1ns/1ps
module cbd_regs
  import ctr_blk_dma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 16,
  parameter logic [7:0] REG_PAGE = 8'hFF
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   host_wr,
  input  logic                   host_rd,
  input  logic [ADDR_W-1:0]      host_addr,
  input  logic [7:0]             host_wdata,
  output logic [7:0]             host_rdata,
  input  logic                   busy,
  output logic                   start,
  output logic [ADDR_W-1:0]      cfg_base,
  output logic [ADDR_W-1:0]      cfg_len,
  output logic [7:0]             cfg_ksel,
  output logic [BLK_BYTES*8-1:0] cfg_ctr,
  output logic [BLK_BYTES*8-1:0] cfg_key0,
  output logic [BLK_BYTES*8-1:0] cfg_key1
);
  localparam int IDX_W = $clog2(BLK_BYTES);

  logic             page_hit;
  logic [7:0]       ofs;
  logic [IDX_W-1:0] lane;
  logic             wr_ok;
  logic [7:0]       rd_val;

  assign page_hit = (host_addr[ADDR_W-1 -: 8] == REG_PAGE);
  assign ofs      = host_addr[7:0];
  assign lane     = ofs[IDX_W-1:0];
  assign wr_ok    = host_wr && page_hit && !busy;
  assign start    = wr_ok && (ofs == OFS_CTRL) && (host_wdata == START_CODE);

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_base <= '0;
      cfg_len  <= '0;
      cfg_ksel <= '0;
      cfg_ctr  <= '0;
      cfg_key0 <= '0;
      cfg_key1 <= '0;
    end else if (wr_ok) begin
      case (ofs)
        OFS_KSEL:    cfg_ksel        <= host_wdata;
        OFS_BASE_LO: cfg_base[7:0]   <= host_wdata;
        OFS_BASE_HI: cfg_base[15:8]  <= host_wdata;
        OFS_LEN_LO:  cfg_len[7:0]    <= host_wdata;
        OFS_LEN_HI:  cfg_len[15:8]   <= host_wdata;
        default: begin
          if (ofs[7:4] == PG_CTR)  cfg_ctr[{lane, 3'b000} +: 8]  <= host_wdata;
          if (ofs[7:4] == PG_KEY0) cfg_key0[{lane, 3'b000} +: 8] <= host_wdata;
          if (ofs[7:4] == PG_KEY1) cfg_key1[{lane, 3'b000} +: 8] <= host_wdata;
        end
      endcase
    end
  end

  always_comb begin
    rd_val = '0;
    if (page_hit) begin
      case (ofs)
        OFS_CTRL:    rd_val = {7'd0, busy};
        OFS_KSEL:    rd_val = cfg_ksel;
        OFS_BASE_LO: rd_val = cfg_base[7:0];
        OFS_BASE_HI: rd_val = cfg_base[15:8];
        OFS_LEN_LO:  rd_val = cfg_len[7:0];
        OFS_LEN_HI:  rd_val = cfg_len[15:8];
        default: begin
          if (ofs[7:4] == PG_CTR)  rd_val = cfg_ctr[{lane, 3'b000} +: 8];
          if (ofs[7:4] == PG_KEY0) rd_val = cfg_key0[{lane, 3'b000} +: 8];
          if (ofs[7:4] == PG_KEY1) rd_val = cfg_key1[{lane, 3'b000} +: 8];
        end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_val;
    else              host_rdata <= '0;
  end
endmodule

// File: rtl/cbd_keysel.sv
`timescale 1ns/1ps
module cbd_keysel #(
  parameter int BLK_W = 128
) (
  input  logic [7:0]       ksel,
  input  logic [BLK_W-1:0] key0,
  input  logic [BLK_W-1:0] key1,
  output logic [BLK_W-1:0] key_out
);
  // any nonzero selector picks the second key
  assign key_out = (ksel == 8'd0) ? key0 : key1;
endmodule

// File: rtl/cbd_seq.sv
`timescale 1ns/1ps
module cbd_seq
  import ctr_blk_dma_pkg::*;
#(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   start,
  input  logic [ADDR_W-1:0]      cfg_base,
  input  logic [ADDR_W-1:0]      cfg_len,
  output logic                   busy,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [ADDR_W-1:0]      mem_addr,
  output logic [7:0]             mem_wdata,
  input  logic                   mem_ready,
  input  logic [7:0]             mem_rdata,
  output logic                   cph_req,
  output logic [BLK_BYTES*8-1:0] cph_block,
  input  logic                   cph_ack,
  input  logic [BLK_BYTES*8-1:0] cph_result
);
  localparam int BLK_W = BLK_BYTES * 8;
  localparam int IDX_W = $clog2(BLK_BYTES);
  localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(BLK_BYTES - 1);
  localparam logic [ADDR_W-1:0] BLK_STEP = ADDR_W'(BLK_BYTES);

  seq_state_t        st_q;
  logic [IDX_W-1:0]  idx_q;
  logic [ADDR_W-1:0] done_q;
  logic [ADDR_W-1:0] done_nx;
  logic [BLK_W-1:0]  blk_q;
  logic              fire;
  logic              last_byte;

  assign busy      = (st_q != ST_IDLE);
  assign mem_req   = (st_q == ST_READ) || (st_q == ST_WRBK);
  assign mem_we    = (st_q == ST_WRBK);
  assign mem_addr  = cfg_base + done_q + ADDR_W'(idx_q);
  assign mem_wdata = blk_q[{idx_q, 3'b000} +: 8];
  assign cph_req   = (st_q == ST_ENC);
  assign cph_block = blk_q;
  assign fire      = mem_req && mem_ready;
  assign last_byte = (idx_q == LAST_IDX);
  assign done_nx   = done_q + BLK_STEP;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      idx_q  <= '0;
      done_q <= '0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (start) begin
            st_q   <= ST_READ;
            idx_q  <= '0;
            done_q <= '0;
          end
        end
        ST_READ: begin
          if (fire) begin
            idx_q <= idx_q + 1'b1;
            if (last_byte) st_q <= ST_ENC;
          end
        end
        ST_ENC: begin
          if (cph_ack) st_q <= ST_WRBK;
        end
        ST_WRBK: begin
          if (fire) begin
            idx_q <= idx_q + 1'b1;
            if (last_byte) begin
              done_q <= done_nx;
              st_q   <= (done_nx < cfg_len) ? ST_READ : ST_IDLE;
            end
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // byte lane packing of the block buffer
  always_ff @(posedge clk) begin
    if (rst) begin
      blk_q <= '0;
    end else if ((st_q == ST_ENC) && cph_ack) begin
      blk_q <= cph_result;
    end else if ((st_q == ST_READ) && fire) begin
      for (int b = 0; b < BLK_BYTES; b++) begin
        if (idx_q == IDX_W'(b)) blk_q[b*8 +: 8] <= mem_rdata;
      end
    end
  end
endmodule

// File: rtl/ctr_blk_dma.sv
`timescale 1ns/1ps
module ctr_blk_dma #(
  parameter int ADDR_W    = 16,
  parameter int BLK_BYTES = 16,
  parameter logic [7:0] REG_PAGE = 8'hFF
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          host_wr,
  input  logic          host_rd,
  input  logic [15:0]   host_addr,
  input  logic [7:0]    host_wdata,
  output logic [7:0]    host_rdata,
  output logic          mem_req,
  output logic          mem_we,
  output logic [15:0]   mem_addr,
  output logic [7:0]    mem_wdata,
  input  logic          mem_ready,
  input  logic [7:0]    mem_rdata,
  output logic          cph_req,
  output logic [127:0]  cph_block,
  output logic [127:0]  cph_ctr,
  output logic [127:0]  cph_key,
  input  logic          cph_ack,
  input  logic [127:0]  cph_result
);
  localparam int BLK_W = BLK_BYTES * 8;

  logic              busy;
  logic              start;
  logic [ADDR_W-1:0] cfg_base;
  logic [ADDR_W-1:0] cfg_len;
  logic [7:0]        cfg_ksel;
  logic [BLK_W-1:0]  cfg_ctr;
  logic [BLK_W-1:0]  cfg_key0;
  logic [BLK_W-1:0]  cfg_key1;

  cbd_regs #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES), .REG_PAGE(REG_PAGE)) u_regs (
    .clk(clk), .rst(rst),
    .host_wr(host_wr), .host_rd(host_rd), .host_addr(host_addr),
    .host_wdata(host_wdata), .host_rdata(host_rdata),
    .busy(busy), .start(start),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .cfg_ksel(cfg_ksel),
    .cfg_ctr(cfg_ctr), .cfg_key0(cfg_key0), .cfg_key1(cfg_key1)
  );

  cbd_seq #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) u_seq (
    .clk(clk), .rst(rst), .start(start),
    .cfg_base(cfg_base), .cfg_len(cfg_len), .busy(busy),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ready(mem_ready), .mem_rdata(mem_rdata),
    .cph_req(cph_req), .cph_block(cph_block),
    .cph_ack(cph_ack), .cph_result(cph_result)
  );

  cbd_keysel #(.BLK_W(BLK_W)) u_keysel (
    .ksel(cfg_ksel), .key0(cfg_key0), .key1(cfg_key1), .key_out(cph_key)
  );

  assign cph_ctr = cfg_ctr;
endmodule

// File: rtl/ctr_blk_dma_ckr.sv
`timescale 1ns/1ps
module ctr_blk_dma_ckr (
  input logic         clk,
  input logic         rst,
  input logic         host_wr,
  input logic         host_rd,
  input logic [15:0]  host_addr,
  input logic [7:0]   host_wdata,
  input logic [7:0]   host_rdata,
  input logic         mem_req,
  input logic         mem_we,
  input logic [15:0]  mem_addr,
  input logic [7:0]   mem_wdata,
  input logic         mem_ready,
  input logic         cph_req,
  input logic [127:0] cph_block,
  input logic         cph_ack,
  input logic         busy,
  input logic [15:0]  cfg_base
);
  logic start_seen;
  assign start_seen = host_wr && (host_addr == 16'hFF00) && (host_wdata == 8'h01) && !busy;

  p_start_busy_r2: assert property (@(posedge clk) disable iff (rst)
    start_seen |=> busy);

  p_first_fetch_r4: assert property (@(posedge clk) disable iff (rst)
    start_seen |-> !mem_req ##1 (mem_req && !mem_we && mem_addr == cfg_base));

  p_addr_step_r5: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ready) |=> (!mem_req || mem_addr == $past(mem_addr) + 16'd1));

  p_cph_hold_r6: assert property (@(posedge clk) disable iff (rst)
    (cph_req && !cph_ack) |=> (cph_req && $stable(cph_block)));

  p_rd_miss_r9: assert property (@(posedge clk) disable iff (rst)
    (host_rd && host_addr[15:8] != 8'hFF) |=> host_rdata == 8'h00);

  p_no_read_zero_r9: assert property (@(posedge clk) disable iff (rst)
    !host_rd |=> host_rdata == 8'h00);

  p_idle_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!mem_req && !cph_req));

  p_req_hold_r11: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ready) |=> (mem_req && $stable(mem_addr) && $stable(mem_we) && $stable(mem_wdata)));

  p_one_port_r11: assert property (@(posedge clk) disable iff (rst)
    !(mem_req && cph_req));
endmodule

bind ctr_blk_dma ctr_blk_dma_ckr u_ckr (
  .clk(clk), .rst(rst), .host_wr(host_wr), .host_rd(host_rd),
  .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
  .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_ready(mem_ready),
  .cph_req(cph_req), .cph_block(cph_block), .cph_ack(cph_ack),
  .busy(busy), .cfg_base(cfg_base)
);

// File: tb/tb_ctr_blk_dma.sv
`timescale 1ns/1ps
module tb_ctr_blk_dma;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         host_wr = 1'b0;
  logic         host_rd = 1'b0;
  logic [15:0]  host_addr = '0;
  logic [7:0]   host_wdata = '0;
  logic [7:0]   host_rdata;
  logic         mem_req, mem_we;
  logic [15:0]  mem_addr;
  logic [7:0]   mem_wdata;
  logic         mem_ready = 1'b1;
  logic [7:0]   mem_rdata;
  logic         cph_req;
  logic [127:0] cph_block, cph_ctr, cph_key;
  logic         cph_ack = 1'b0;
  logic [127:0] cph_result = '0;

  int n_chk = 0;
  int n_bad = 0;
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  ctr_blk_dma dut (.*);

  // byte memory model, 256 bytes indexed by the low address byte
  logic [7:0] bmem [256];
  logic [7:0] orig [256];
  assign mem_rdata = bmem[mem_addr[7:0]];
  always @(posedge clk) if (mem_req && mem_ready && mem_we) bmem[mem_addr[7:0]] <= mem_wdata;

  bit stall_on = 0;
  int stall_cnt = 0;
  always @(negedge clk) begin
    stall_cnt <= stall_cnt + 1;
    mem_ready <= !stall_on || (stall_cnt % 3 != 0);
  end

  // cipher responder: result = block ^ ctr ^ key, ack after 3 cycles
  int dly = 0;
  int ack_cnt = 0;
  logic [127:0] seen_key, seen_ctr;
  always @(negedge clk) begin
    if (cph_ack) cph_ack <= 1'b0;
    else if (cph_req) begin
      if (dly == 2) begin
        cph_ack    <= 1'b1;
        cph_result <= cph_block ^ cph_ctr ^ cph_key;
        seen_key   <= cph_key;
        seen_ctr   <= cph_ctr;
        ack_cnt    <= ack_cnt + 1;
        dly        <= 0;
      end else dly <= dly + 1;
    end
  end

  function automatic logic [7:0] ctr_b(int k);  return 8'(8'h10 + k);   endfunction
  function automatic logic [7:0] key0_b(int k); return 8'(8'hA0 ^ k);   endfunction
  function automatic logic [7:0] key1_b(int k); return 8'(8'h5C + 3*k); endfunction

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic hwrite(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    host_wr = 1'b1; host_addr = a; host_wdata = d;
    @(negedge clk);
    host_wr = 1'b0;
  endtask

  task automatic hread(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk);
    host_rd = 1'b1; host_addr = a;
    @(negedge clk);
    host_rd = 1'b0;
    d = host_rdata;
  endtask

  task automatic wait_idle();
    logic [7:0] v;
    for (int i = 0; i < 3000; i++) begin
      hread(16'hFF00, v);
      if (v[0] == 1'b0) return;
    end
  endtask

  task automatic fill_mem(input int seed);
    for (int i = 0; i < 256; i++) begin
      bmem[i] = 8'(i * 7 + 3 + seed);
      orig[i] = 8'(i * 7 + 3 + seed);
    end
  endtask

  // {base, len, key select, stall}
  localparam int NV = 6;
  localparam logic [40:0] VEC [NV] = '{
    {16'h0040, 16'd16, 8'd0, 1'b0},
    {16'h0080, 16'd0,  8'd1, 1'b1},
    {16'h0010, 16'd17, 8'd0, 1'b1},
    {16'h00A0, 16'd32, 8'd2, 1'b0},
    {16'hFFF8, 16'd48, 8'd0, 1'b1},
    {16'h0003, 16'd33, 8'd1, 1'b0}
  };

  initial begin
    logic [7:0] v;
    logic [127:0] exp_key, exp_ctr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(mem_req == 0 && cph_req == 0 && host_rdata == 0, "R1 outputs idle", {mem_req, cph_req, host_rdata}, 0);
    hread(16'hFF00, v); chk(v == 0, "R1 busy reads 0", v, 0);
    hread(16'hFF03, v); chk(v == 0, "R1 base high reset", v, 0);

    // program counter and keys
    for (int k = 0; k < 16; k++) begin
      hwrite(16'hFF10 + 16'(k), ctr_b(k));
      hwrite(16'hFF20 + 16'(k), key0_b(k));
      hwrite(16'hFF30 + 16'(k), key1_b(k));
    end
    // R9 readback and unmapped
    hread(16'hFF15, v); chk(v == 8'h15, "R9 counter byte 5", v, 8'h15);
    hread(16'hFF2A, v); chk(v == (8'hA0 ^ 8'd10), "R9 key0 byte 10", v, 8'hAA);
    hread(16'h1234, v); chk(v == 0, "R9 other page", v, 0);
    hread(16'hFF40, v); chk(v == 0, "R9 unmapped in page", v, 0);

    // R2 non-start value
    hwrite(16'hFF00, 8'h02);
    hread(16'hFF00, v); chk(v == 0, "R2 code 2 no start", v, 0);
    chk(mem_req == 0, "R2 no memory traffic", mem_req, 0);

    for (int n = 0; n < NV; n++) begin
      logic [15:0] base, len;
      logic [7:0]  ks;
      int nblk, bad, a0, a_after;
      logic [7:0] e, act_b, exp_b;
      {base, len, ks, stall_on} = VEC[n];
      nblk = (len == 0) ? 1 : (int'(len) + 15) / 16;
      fill_mem(n * 13);
      hwrite(16'hFF02, base[7:0]);  hwrite(16'hFF03, base[15:8]);
      hwrite(16'hFF04, len[7:0]);   hwrite(16'hFF05, len[15:8]);
      hwrite(16'hFF01, ks);
      hread(16'hFF04, v); chk(v == len[7:0], "R9 length low readback", v, len[7:0]);
      a0 = ack_cnt;
      // start, observed cycle by cycle (R4)
      @(negedge clk);
      host_wr = 1'b1; host_addr = 16'hFF00; host_wdata = 8'h01;
      chk(mem_req == 0, "R4 no access in start cycle", mem_req, 0);
      @(negedge clk);
      host_wr = 1'b0;
      chk(mem_req == 1 && mem_we == 0 && mem_addr == base, "R4 first fetch at base", {mem_req, mem_we, mem_addr}, {2'b10, base});
      hread(16'hFF00, v); chk(v == 8'h01, "R10 busy while running", v, 1);
      if (n == 2) hwrite(16'hFF02, 8'h77); // R3 write while busy
      wait_idle();
      chk(ack_cnt - a0 == nblk, "R8 block count", ack_cnt - a0, nblk);
      exp_key = '0; exp_ctr = '0;
      for (int k = 0; k < 16; k++) begin
        exp_key[k*8 +: 8] = (ks == 0) ? key0_b(k) : key1_b(k);
        exp_ctr[k*8 +: 8] = ctr_b(k);
      end
      chk(seen_key == exp_key, "R6 key select", seen_key, exp_key);
      chk(seen_ctr == exp_ctr, "R6 counter passed", seen_ctr, exp_ctr);
      bad = 0; act_b = 0; exp_b = 0;
      for (int j = 0; j < nblk * 16; j++) begin
        int a;
        a = (int'(base[7:0]) + j) % 256;
        e = orig[a] ^ ctr_b(j % 16) ^ ((ks == 0) ? key0_b(j % 16) : key1_b(j % 16));
        if (bmem[a] != e && bad == 0) begin act_b = bmem[a]; exp_b = e; end
        if (bmem[a] != e) bad++;
      end
      chk(bad == 0, "R5 R7 transformed bytes", act_b, exp_b);
      a_after = (int'(base[7:0]) + nblk * 16) % 256;
      chk(bmem[a_after] == orig[a_after], "R8 byte past end untouched", bmem[a_after], orig[a_after]);
      if (n == 2) begin
        hread(16'hFF02, v); chk(v == 8'h10, "R3 busy write ignored", v, 8'h10);
      end
      hread(16'hFF00, v); chk(v == 0, "R10 idle after finish", v, 0);
    end
    stall_on = 0;
    chk(mem_req == 0 && cph_req == 0, "R11 quiet after runs", {mem_req, cph_req}, 0);

    if (!done_flag) begin
      done_flag = 1;
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog act=%0d exp=%0d", 1, 0);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule